// File: doc/BRIEF.md
# Pin Port with Atomic Output Update and Event Flags

This block is a bank of general-purpose pins, 32 by default, sitting behind a simple register bus. Software chooses a drive direction for each pin and holds an output level for it. Three write-only mask registers force chosen output bits high, force them low or invert them in a single bus write. Because of this, two agents that update different pins never have to read, modify and write the same word and so cannot overwrite each other's change.

Every incoming pin level passes through a multi-flop synchronizer. The synchronized levels are readable as one word, and they also feed a per-pin event detector. Each pin can be set to watch for a rising edge, a falling edge, either edge, a high level, a low level, or a rising edge that requests a DMA transfer instead of an interrupt. A detected event sets a sticky flag. Software clears a flag by writing a 1 to its bit. A DMA completion pulse clears the flag of a pin in DMA mode. A level condition that is still present sets its flag again at once.

Top module: `gpio_port`

## Requirements
- R1: The direction register (address 0x0) resets to zero and reads back as written. Output-enable bit n follows direction bit n, where 1 means output and 0 means input.
- R2: A write to the set register (address 0x2) drives high every output bit whose mask bit is 1. The change shows on the pins one cycle after the write.
- R3: A write to the clear register (address 0x3) drives low every output bit whose mask bit is 1.
- R4: A write to the toggle register (address 0x4) inverts every output bit whose mask bit is 1. For the set, clear and toggle registers, output bits whose mask bit is 0 keep their value. The output register (address 0x1) reads back the current levels.
- R5: The set, clear and toggle registers read as zero. A read returns its data, with its valid strobe, in the cycle after the request.
- R6: The input register (address 0x5) returns the synchronized pin levels, with bit n for pin n. A pin change is visible to a read issued two cycles after the change.
- R7: An interrupt flag (address 0x6) stays set until a 1 is written to its bit. Flag bits written as 0 are unaffected.
- R8: Each pin has a 3-bit mode in the configuration words, starting at address 0x8. Each word holds eight pins, and pin 8k+j uses bits [4j+2:4j] of word k. The codes are: 0 off, 1 rising, 2 falling, 3 either edge, 4 high level, 5 low level, 6 rising edge with DMA, 7 off. A pin whose mode is off never sets its flag.
- R9: In a level mode, if the level is still present, the flag is set again in the same cycle it is cleared, so a clear write leaves it set.
- R10: In mode 6, the flag drives that pin's DMA request bit. A dma_done pulse on that bit clears the flag.
- R11: The irq output is high when any flag of a pin not in mode 6 is set. A DMA-mode flag alone leaves irq low.
- R12: When a new event and a clear (either a write-one or a DMA completion) land on the same flag in the same cycle, the event wins and the flag stays set.
- R13: After reset, the outputs, output enables, flags, irq and DMA requests are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access request, one cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after the request |
| pin_in | input | NPINS | Raw pin levels, asynchronous |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output enables |
| irq | output | 1 | Interrupt request |
| dma_req | output | NPINS | Per-pin DMA request |
| dma_done | input | NPINS | Per-pin DMA completion pulse |

## Verification
The interesting collision is a flag being cleared in the very cycle its event detector fires. This can happen through a write-one-to-clear or through a DMA completion. The bench moves a pin, then counts the two synchronizer stages and the edge register so that the clearing write or the dma_done pulse lands on the exact edge where the detector sets the flag. It then reads the flag, or samples the DMA request, and expects it to be set. The same flag cleared one cycle later must read as zero, which shows that the clear itself works and that only the coincidence is being judged.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;
  localparam int PINS_PER_CFG = 8;

  localparam logic [ADDR_W-1:0] A_DIR  = 4'h0;
  localparam logic [ADDR_W-1:0] A_OUT  = 4'h1;
  localparam logic [ADDR_W-1:0] A_SET  = 4'h2;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'h3;
  localparam logic [ADDR_W-1:0] A_TGL  = 4'h4;
  localparam logic [ADDR_W-1:0] A_IN   = 4'h5;
  localparam logic [ADDR_W-1:0] A_FLG  = 4'h6;
  localparam logic [ADDR_W-1:0] A_CFG0 = 4'h8;

  typedef enum logic [2:0] {
    EV_OFF  = 3'd0,
    EV_RISE = 3'd1,
    EV_FALL = 3'd2,
    EV_BOTH = 3'd3,
    EV_HIGH = 3'd4,
    EV_LOW  = 3'd5,
    EV_DMA  = 3'd6,
    EV_RSVD = 3'd7
  } evt_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   lvl,
  input  logic [3*NPINS-1:0] cfg,
  input  logic [NPINS-1:0]   clr_mask,
  input  logic [NPINS-1:0]   dma_done,
  output logic [NPINS-1:0]   flags,
  output logic [NPINS-1:0]   dma_req,
  output logic               irq
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] flag_q, flag_d;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] dma_sel;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [2:0] mode;
    assign mode = cfg[3*p +: 3];
    assign dma_sel[p] = (mode == EV_DMA);

    always_comb begin
      case (mode)
        EV_RISE, EV_DMA: hit[p] = lvl[p] & ~prev_q[p];
        EV_FALL:         hit[p] = ~lvl[p] & prev_q[p];
        EV_BOTH:         hit[p] = lvl[p] ^ prev_q[p];
        EV_HIGH:         hit[p] = lvl[p];
        EV_LOW:          hit[p] = ~lvl[p];
        default:         hit[p] = 1'b0;
      endcase
    end
  end

  // A fresh event outranks any clear landing in the same cycle.
  always_comb begin
    flag_d = hit | (flag_q & ~clr_mask & ~(dma_sel & dma_done));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl;
      flag_q <= flag_d;
    end
  end

  assign flags   = flag_q;
  assign dma_req = flag_q & dma_sel;
  assign irq     = |(flag_q & ~dma_sel);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq,
  output logic [NPINS-1:0]  dma_req,
  input  logic [NPINS-1:0]  dma_done
);
  localparam int CFG_WORDS = (NPINS + PINS_PER_CFG - 1) / PINS_PER_CFG;
  localparam int CFG_W     = 3 * NPINS;

  logic               wr_en, rd_en;
  logic [NPINS-1:0]   wmask;
  logic [NPINS-1:0]   dir_q, dir_d;
  logic [NPINS-1:0]   out_q, out_d;
  logic [CFG_W-1:0]   cfg_q, cfg_d;
  logic [BUS_W-1:0]   rdata_q, rdata_d;
  logic               rvalid_q;
  logic [NPINS-1:0]   lvl_sync;
  logic [NPINS-1:0]   flags_q;
  logic [NPINS-1:0]   w1c_mask;

  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;
  assign wmask = bus_wdata[NPINS-1:0];

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (lvl_sync)
  );

  assign w1c_mask = (wr_en && bus_addr == A_FLG) ? wmask : '0;

  gpio_evt #(.NPINS(NPINS)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl_sync),
    .cfg     (cfg_q),
    .clr_mask(w1c_mask),
    .dma_done(dma_done),
    .flags   (flags_q),
    .dma_req (dma_req),
    .irq     (irq)
  );

  // Register file next state
  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    cfg_d = cfg_q;
    if (wr_en) begin
      case (bus_addr)
        A_DIR:   dir_d = wmask;
        A_OUT:   out_d = wmask;
        A_SET:   out_d = out_q | wmask;
        A_CLR:   out_d = out_q & ~wmask;
        A_TGL:   out_d = out_q ^ wmask;
        default: ;
      endcase
      for (int p = 0; p < NPINS; p++) begin
        if (bus_addr == ADDR_W'(32'(A_CFG0) + p / PINS_PER_CFG))
          cfg_d[3*p +: 3] = bus_wdata[4*(p % PINS_PER_CFG) +: 3];
      end
    end
  end

  // Read mux next state
  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      A_DIR:   rdata_d[NPINS-1:0] = dir_q;
      A_OUT:   rdata_d[NPINS-1:0] = out_q;
      A_IN:    rdata_d[NPINS-1:0] = lvl_sync;
      A_FLG:   rdata_d[NPINS-1:0] = flags_q;
      default: ;
    endcase
    for (int p = 0; p < NPINS; p++) begin
      if (bus_addr == ADDR_W'(32'(A_CFG0) + p / PINS_PER_CFG))
        rdata_d[4*(p % PINS_PER_CFG) +: 3] = cfg_q[3*p +: 3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      out_q    <= '0;
      cfg_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (wr_en) begin
        dir_q <= dir_d;
        out_q <= out_d;
        cfg_q <= cfg_d;
      end
      if (rd_en) rdata_q <= rdata_d;
      rvalid_q <= rd_en;
    end
  end

  assign pin_out    = out_q;
  assign pin_oe     = dir_q;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  if (CFG_WORDS > 8) begin : g_bad_cfg
    initial $error("gpio_port: NPINS too large for the address map");
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              bus_rvalid,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  dma_req,
  input logic [NPINS-1:0]  dma_done,
  input logic [NPINS-1:0]  flags_q
);
  logic [NPINS-1:0] m;
  logic [NPINS-1:0] clr_any;
  logic             wr, rd;

  assign m  = bus_wdata[NPINS-1:0];
  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;
  assign clr_any = ((wr && bus_addr == A_FLG) ? m : '0) | dma_done;

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_DIR) |=> (pin_oe == $past(m))); // R1
  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_SET) |=> ((pin_out & $past(m)) == $past(m))); // R2
  AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_CLR) |=> ((pin_out & $past(m)) == '0)); // R3
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_TGL) |=> ((pin_out ^ $past(pin_out)) == $past(m))); // R4
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (bus_addr == A_SET || bus_addr == A_CLR || bus_addr == A_TGL))
      |=> (bus_rvalid && bus_rdata == '0)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_q) & ~flags_q & ~$past(clr_any)) == '0)); // R7
  AST_DMA_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_req & ~flags_q) == '0)); // R10
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .dma_req   (dma_req),
  .dma_done  (dma_done),
  .flags_q   (flags_q)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  import gpio_port_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [BUS_W-1:0]  bus_wdata;
  logic [BUS_W-1:0]  bus_rdata;
  logic              bus_rvalid;
  logic [NP-1:0]     pin_in, pin_out, pin_oe, dma_req, dma_done;
  logic              irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.NPINS(NP)) dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq), .dma_req(dma_req), .dma_done(dma_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: pop one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (sbq.size() == 0) begin
        chk("unexpected read data", bus_rdata, 32'hxxxx_xxxx);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, bus_rdata, e.v);
      end
    end
  end

  // All tasks are entered at a falling edge and return at the next one.
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.v = exp; e.tag = tag;
    sbq.push_back(e);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic dma_pulse(input logic [31:0] m);
    dma_done = m;
    @(negedge clk);
    dma_done = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; dma_done = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R13 reset state
    chk("R13 pin_out", pin_out, 0);
    chk("R13 pin_oe", pin_oe, 0);
    chk("R13 irq", {31'b0, irq}, 0);
    chk("R13 dma_req", dma_req, 0);
    bus_rd(A_OUT, 0, "R13 output reg");
    bus_rd(A_FLG, 0, "R13 flags");
    bus_rd(A_DIR, 0, "R1 dir reset");

    // R1 direction
    bus_wr(A_DIR, 32'h0000_FFFF);
    chk("R1 pin_oe", pin_oe, 32'h0000_FFFF);
    bus_rd(A_DIR, 32'h0000_FFFF, "R1 dir readback");

    // R2 / R3 / R4 atomic ops
    bus_wr(A_SET, 32'h8000_0101);
    chk("R2 set", pin_out, 32'h8000_0101);
    bus_wr(A_CLR, 32'h0000_0100);
    chk("R3 clear", pin_out, 32'h8000_0001);
    bus_wr(A_TGL, 32'h0000_0003);
    chk("R4 toggle", pin_out, 32'h8000_0002);
    bus_rd(A_OUT, 32'h8000_0002, "R4 output readback");

    // R5 write-only registers read zero
    bus_rd(A_SET, 0, "R5 set reads 0");
    bus_rd(A_CLR, 0, "R5 clear reads 0");
    bus_rd(A_TGL, 0, "R5 toggle reads 0");

    // R6 input register
    pin_in = 32'h0001_0001;
    tick(2);
    bus_rd(A_IN, 32'h0001_0001, "R6 input pins 0 and 16");
    pin_in = 32'hA5A5_0000;
    tick(2);
    bus_rd(A_IN, 32'hA5A5_0000, "R6 input pattern");
    pin_in = '0;
    tick(4);

    // R8 modes: pin0 rise, pin1 fall, pin2 both, pin3 rise, pin4 off
    bus_wr(A_CFG0, 32'h0000_1321);
    bus_rd(A_CFG0, 32'h0000_1321, "R8 cfg readback");
    bus_rd(A_FLG, 0, "R8 no flags yet");
    pin_in[4:0] = 5'b11111;
    tick(4);
    bus_rd(A_FLG, 32'h0000_000D, "R8 rising edges");
    chk("R11 irq on edge flag", {31'b0, irq}, 1);
    bus_wr(A_FLG, 32'h0000_001F);
    bus_rd(A_FLG, 0, "R7 w1c all");
    pin_in[4:0] = 5'b00000;
    tick(4);
    bus_rd(A_FLG, 32'h0000_0006, "R8 falling edges");
    bus_wr(A_FLG, 32'h0000_0002);
    bus_rd(A_FLG, 32'h0000_0004, "R7 zero bits keep flag");
    bus_wr(A_FLG, 32'h0000_0004);
    bus_rd(A_FLG, 0, "R7 w1c second");
    chk("R11 irq low", {31'b0, irq}, 0);

    // R9 level modes: pin8 high, pin9 low
    bus_wr(4'h9, 32'h0000_0054);
    tick(2);
    bus_rd(A_FLG, 32'h0000_0200, "R9 low level flag");
    bus_wr(A_FLG, 32'h0000_0200);
    bus_rd(A_FLG, 32'h0000_0200, "R9 low level re-asserts");
    pin_in[9] = 1'b1;
    tick(4);
    bus_wr(A_FLG, 32'h0000_0200);
    bus_rd(A_FLG, 0, "R9 cleared once level gone");
    pin_in[8] = 1'b1;
    tick(4);
    bus_wr(A_FLG, 32'h0000_0100);
    bus_rd(A_FLG, 32'h0000_0100, "R9 high level re-asserts");
    pin_in[8] = 1'b0;
    tick(4);
    bus_wr(4'h9, 32'h0);
    bus_wr(A_FLG, 32'h0000_0300);
    bus_rd(A_FLG, 0, "R9 flags clear after mode off");
    pin_in[9] = 1'b0;

    // R12 event coincides with write-one clear (pin3 rising)
    pin_in[3] = 1'b1;
    tick(2);
    bus_wr(A_FLG, 32'h0000_0008);
    bus_rd(A_FLG, 32'h0000_0008, "R12 event beats w1c");
    chk("R12 irq held", {31'b0, irq}, 1);
    bus_wr(A_FLG, 32'h0000_0008);
    bus_rd(A_FLG, 0, "R12 later w1c clears");
    pin_in[3] = 1'b0;
    tick(4);
    bus_rd(A_FLG, 0, "R8 rising mode ignores fall");

    // R10 / R11 DMA mode on pin16
    bus_wr(4'hA, 32'h0000_0006);
    pin_in[16] = 1'b1;
    tick(4);
    chk("R10 dma_req", dma_req, 32'h0001_0000);
    chk("R11 no irq for dma flag", {31'b0, irq}, 0);
    bus_rd(A_FLG, 32'h0001_0000, "R10 dma flag");
    dma_pulse(32'h0001_0000);
    chk("R10 dma_done clears", dma_req, 0);
    bus_rd(A_FLG, 0, "R10 flag cleared by dma");
    pin_in[16] = 1'b0;
    tick(4);
    pin_in[16] = 1'b1;
    tick(2);
    dma_pulse(32'h0001_0000);
    chk("R12 event beats dma_done", dma_req, 32'h0001_0000);
    dma_pulse(32'h0001_0000);
    chk("R10 second dma_done clears", dma_req, 0);

    tick(3);
    chk("scoreboard drained", sbq.size(), 0);
    finish_run();
  end
endmodule